// File: doc/BRIEF.md
# Single-Wire Identity Responder

This block is a slave on a single-wire, open-drain bus. It owns a fixed 64-bit identity built from parameters and hands it to the bus master on request. It never drives the line high. It watches a synchronized copy of the line and drives one active-low enable for an external pull-down transistor. All timing is counted in microsecond ticks from a tick-enable input.

Every transaction opens with a long low pulse from the master. The block answers with a presence pulse and then receives an 8-bit command. Depending on the command, it streams its identity, joins a bit-by-bit search among several slaves, or stays silent until the next long low pulse. Each bit slot begins when the master pulls the line low. The block samples written bits a fixed time after that edge. To return a 0 it holds the line low for a fixed time; to return a 1 it leaves the line released.

Top module: `owid_responder`

## Requirements
- R1: While `rst` is high and afterwards, `pull_n` stays 1. Until the first bus reset is seen, the block ignores all slots: read slots return 1.
- R2: A low of at least RST_US ticks, not caused by the block, followed by release, makes the block wait PD_WAIT_US ticks and then drive `pull_n` low for PD_LEN_US ticks (defaults 480, 30 and 120). Each of these may be off by one tick.
- R3: A low shorter than RST_US does not produce a presence pulse.
- R4: Command bits are taken least significant bit first. Each bit is the line level SAMPLE_US ticks (default 30) after the master's falling edge.
- R5: After command 33h or 0Fh, each read slot returns one identity bit, bit 0 first. A 0 holds the line low for HOLD0_US ticks (default 30) from the falling edge. A 1 leaves the line released.
- R6: Identity bits 7:0 hold the family code (default 01h) and bits 55:8 the serial number. Bits 63:56 hold a CRC-8 of bits 55:0, taken bit 0 first, with polynomial x^8+x^5+x^4+1 in reflected form (0x8C), a zero start value and no final inversion.
- R7: Once all 64 identity bits have been read, later read slots return 1 until the next bus reset.
- R8: After command 55h, CCh or any code not named in R5 or R9, the block drives nothing until the next bus reset.
- R9: After command F0h, each identity bit, bit 0 first, uses three slots: a read slot returning the bit, a read slot returning its complement, and a write slot. A written value equal to the bit moves on to the next bit.
- R10: During the search, a written value that differs from the current bit silences the block until the next bus reset.
- R11: A low lasting ABORT_US ticks (default 120) during a command, read or search silences the block until the next bus reset.
- R12: A bus reset at any point restarts the sequence: presence, then a new command, with the identity starting again at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| line_in | input | 1 | Synchronized level of the bus line |
| pull_n | output | 1 | Registered pull-down enable, 0 pulls the line low |

## Verification
A corrupted bit index or search phase shows up on the line within one slot, as a wrong level at the master's sample point. A slave that should be silent, or a drive that lasts too long, shows on `pull_n` within a few clock cycles. The bench therefore compares `pull_n` on every clock against the level it expects from its own protocol timeline. It also decodes every read slot at the master's sample time and checks the identity it assembles against a CRC computed in the bench.

// File: rtl/owid_pkg.sv
package owid_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // no bus reset seen yet
    ST_ARM,    // long low seen, waiting for release
    ST_PRES,   // presence sequence running
    ST_CMD,    // receiving the command byte
    ST_READ,   // streaming the identity
    ST_SRCH,   // search arbitration
    ST_QUIET   // silent until next bus reset
  } ow_state_e;

  localparam logic [7:0] OP_READ_A = 8'h33;
  localparam logic [7:0] OP_READ_B = 8'h0F;
  localparam logic [7:0] OP_MATCH  = 8'h55;
  localparam logic [7:0] OP_SKIP   = 8'hCC;
  localparam logic [7:0] OP_SEARCH = 8'hF0;

  // reflected CRC-8, polynomial x^8+x^5+x^4+1, bit 0 first
  function automatic logic [7:0] crc8_lsb(input logic [55:0] d);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/owid_linewatch.sv
module owid_linewatch #(
  parameter int RST_US   = 480,
  parameter int ABORT_US = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic line_in,
  input  logic self_mask,
  output logic fall,
  output logic rise,
  output logic rst_hit,
  output logic abort_hit
);
  localparam int CW = $clog2(RST_US + 1);

  logic          line_q;
  logic [CW-1:0] low_cnt;
  logic          low_run;

  assign low_run = tick_us && !line_in && !self_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      line_q <= line_in;
      if (line_in || self_mask)
        low_cnt <= '0;
      else if (tick_us && low_cnt != CW'(RST_US))
        low_cnt <= low_cnt + 1'b1;
    end
  end

  assign fall      = line_q && !line_in && !self_mask;
  assign rise      = !line_q && line_in;
  assign rst_hit   = low_run && (low_cnt == CW'(RST_US - 1));
  assign abort_hit = low_run && (low_cnt == CW'(ABORT_US - 1));

endmodule

// File: rtl/owid_presence.sv
module owid_presence #(
  parameter int WAIT_US = 30,
  parameter int LEN_US  = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic start,
  output logic drv,
  output logic done
);
  localparam int MAXV = (WAIT_US > LEN_US) ? WAIT_US : LEN_US;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [1:0] PH_OFF  = 2'd0;
  localparam logic [1:0] PH_WAIT = 2'd1;
  localparam logic [1:0] PH_DRV  = 2'd2;

  logic [1:0]    phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_OFF;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        phase <= PH_WAIT;
        cnt   <= '0;
      end else if (tick_us) begin
        case (phase)
          PH_WAIT: begin
            if (cnt == CW'(WAIT_US - 1)) begin
              phase <= PH_DRV;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DRV: begin
            if (cnt == CW'(LEN_US - 1)) begin
              phase <= PH_OFF;
              cnt   <= '0;
              done  <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  assign drv = (phase == PH_DRV);

endmodule

// File: rtl/owid_slot.sv
module owid_slot #(
  parameter int SAMPLE_US = 30,
  parameter int HOLD0_US  = 30   // must not exceed SAMPLE_US
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic fall,
  input  logic en,
  input  logic send_zero,
  input  logic line_in,
  output logic drv,
  output logic strobe,
  output logic bit_val
);
  localparam int CW = $clog2(SAMPLE_US + 1);

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      drv     <= 1'b0;
      strobe  <= 1'b0;
      bit_val <= 1'b1;
    end else begin
      strobe <= 1'b0;
      if (fall && en) begin
        active <= 1'b1;
        cnt    <= '0;
        drv    <= send_zero;
      end else if (active && tick_us) begin
        if (cnt == CW'(HOLD0_US - 1)) drv <= 1'b0;
        if (cnt == CW'(SAMPLE_US - 1)) begin
          active  <= 1'b0;
          strobe  <= 1'b1;
          bit_val <= line_in;
        end
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/owid_responder.sv
module owid_responder
  import owid_pkg::*;
#(
  parameter logic [7:0]  FAMILY_CODE = 8'h01,
  parameter logic [47:0] SERIAL_NUM  = 48'h0000_0001_B81C,
  parameter int RST_US     = 480,
  parameter int ABORT_US   = 120,
  parameter int PD_WAIT_US = 30,
  parameter int PD_LEN_US  = 120,
  parameter int SAMPLE_US  = 30,
  parameter int HOLD0_US   = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic line_in,
  output logic pull_n
);
  localparam int ID_BITS = 64;
  localparam int IDX_W   = $clog2(ID_BITS);
  localparam logic [ID_BITS-1:0] ID_VALUE =
    {crc8_lsb({SERIAL_NUM, FAMILY_CODE}), SERIAL_NUM, FAMILY_CODE};

  ow_state_e      state;
  logic [7:0]     cmd_sr;
  logic [7:0]     cmd_next;
  logic [2:0]     cmd_cnt;
  logic [IDX_W-1:0] idx;
  logic [1:0]     ph;
  logic           id_bit;

  logic fall, rise, rst_hit, abort_hit;
  logic pres_start, pres_drv, pres_done, pres_q;
  logic slot_en, send_zero, slot_drv, strobe, bit_val;
  logic in_txn;

  owid_linewatch #(.RST_US(RST_US), .ABORT_US(ABORT_US)) u_watch (
    .clk(clk), .rst(rst), .tick_us(tick_us), .line_in(line_in),
    .self_mask(pres_q), .fall(fall), .rise(rise),
    .rst_hit(rst_hit), .abort_hit(abort_hit)
  );

  owid_presence #(.WAIT_US(PD_WAIT_US), .LEN_US(PD_LEN_US)) u_pres (
    .clk(clk), .rst(rst), .tick_us(tick_us), .start(pres_start),
    .drv(pres_drv), .done(pres_done)
  );

  owid_slot #(.SAMPLE_US(SAMPLE_US), .HOLD0_US(HOLD0_US)) u_slot (
    .clk(clk), .rst(rst), .tick_us(tick_us), .fall(fall), .en(slot_en),
    .send_zero(send_zero), .line_in(line_in), .drv(slot_drv),
    .strobe(strobe), .bit_val(bit_val)
  );

  assign id_bit     = ID_VALUE[idx];
  assign cmd_next   = {bit_val, cmd_sr[7:1]};
  assign in_txn     = (state == ST_CMD) || (state == ST_READ) || (state == ST_SRCH);
  assign slot_en    = in_txn;
  assign pres_start = (state == ST_ARM) && rise;

  always_comb begin
    send_zero = 1'b0;
    if (state == ST_READ)                  send_zero = !id_bit;
    else if (state == ST_SRCH && ph == 2'd0) send_zero = !id_bit;
    else if (state == ST_SRCH && ph == 2'd1) send_zero = id_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cmd_sr  <= '0;
      cmd_cnt <= '0;
      idx     <= '0;
      ph      <= '0;
    end else if (rst_hit) begin
      state <= ST_ARM;
    end else if (abort_hit && in_txn) begin
      state <= ST_QUIET;
    end else begin
      case (state)
        ST_ARM:  if (rise) state <= ST_PRES;
        ST_PRES: begin
          if (pres_done) begin
            state   <= ST_CMD;
            cmd_cnt <= '0;
            idx     <= '0;
            ph      <= '0;
          end
        end
        ST_CMD: begin
          if (strobe) begin
            cmd_sr  <= cmd_next;
            cmd_cnt <= cmd_cnt + 1'b1;
            if (cmd_cnt == 3'd7) begin
              case (cmd_next)
                OP_READ_A, OP_READ_B: state <= ST_READ;
                OP_SEARCH:            state <= ST_SRCH;
                OP_MATCH, OP_SKIP:    state <= ST_QUIET;
                default:              state <= ST_QUIET;
              endcase
            end
          end
        end
        ST_READ: begin
          if (strobe) begin
            if (idx == IDX_W'(ID_BITS - 1)) state <= ST_QUIET;
            else                             idx   <= idx + 1'b1;
          end
        end
        ST_SRCH: begin
          if (strobe) begin
            case (ph)
              2'd0: ph <= 2'd1;
              2'd1: ph <= 2'd2;
              default: begin
                ph <= 2'd0;
                if (bit_val != id_bit || idx == IDX_W'(ID_BITS - 1))
                  state <= ST_QUIET;
                else
                  idx <= idx + 1'b1;
              end
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_n <= 1'b1;
      pres_q <= 1'b0;
    end else begin
      pull_n <= !(pres_drv || slot_drv);
      pres_q <= pres_drv;
    end
  end

endmodule

// File: rtl/owid_checker.sv
module owid_checker
  import owid_pkg::*;
#(
  parameter int PD_LEN_US = 120
) (
  input logic      clk,
  input logic      rst,
  input logic      tick_us,
  input logic      pull_n,
  input logic      fall,
  input logic      pres_drv,
  input logic      slot_drv,
  input ow_state_e state
);
  logic        seen_arm;
  int unsigned pres_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_arm <= 1'b0;
      pres_run <= 0;
    end else begin
      if (state == ST_ARM) seen_arm <= 1'b1;
      if (!pres_drv)                          pres_run <= 0;
      else if (tick_us && pres_run <= PD_LEN_US) pres_run <= pres_run + 1;
    end
  end

  // R1
  release_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pull_n);

  // R1
  silent_before_bus_rst_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_arm |-> pull_n);

  // R2
  presence_len_chk: assert property (@(posedge clk) disable iff (rst)
    pres_run <= PD_LEN_US);

  // R2
  drive_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(pres_drv && slot_drv));

  // R5
  slot_drive_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(slot_drv) |-> $past(fall));

  // R8
  quiet_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_QUIET && $past(state) == ST_QUIET) |-> pull_n);

endmodule

bind owid_responder owid_checker #(.PD_LEN_US(PD_LEN_US)) u_chk (
  .clk(clk), .rst(rst), .tick_us(tick_us), .pull_n(pull_n), .fall(fall),
  .pres_drv(pres_drv), .slot_drv(slot_drv), .state(state)
);

// File: tb/owid_responder_tb.sv
module owid_responder_tb;
  localparam logic [7:0]  FAM    = 8'h01;
  localparam logic [47:0] SER    = 48'h5A3C_9E01_7F24;
  localparam int PD_WAIT = 30;
  localparam int PD_LEN  = 120;
  localparam int M_REL = 0, M_PULL = 1, M_DC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0;
  logic m_low = 1'b0;
  logic line_in;
  logic pull_n;

  int checks = 0, errors = 0;
  int clk_checks = 0, clk_errors = 0;
  int wd_err = 0;
  int exp_mode = M_DC;
  string exp_req = "R1";
  logic [63:0] ref_id;

  always #5 clk = ~clk;
  always @(negedge clk) tick_us <= ~tick_us;
  assign line_in = !(m_low || !pull_n);

  owid_responder #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u_dut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .line_in(line_in), .pull_n(pull_n)
  );

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  // per-clock comparison against the expected line drive
  always @(negedge clk) begin
    if (!rst && exp_mode != M_DC) begin
      clk_checks++;
      if ((exp_mode == M_PULL) == pull_n) begin
        clk_errors++;
        $display("FAIL %s: pull_n=%0b expected %0b at %0t", exp_req, pull_n,
                 (exp_mode == M_REL), $time);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic wr_slot(input logic b);
    exp_mode = M_REL;
    m_low = 1'b1;
    if (b) begin wait_us(3); m_low = 1'b0; wait_us(67); end
    else   begin wait_us(60); m_low = 1'b0; wait_us(10); end
  endtask

  task automatic send_cmd(input logic [7:0] c, input string req);
    exp_req = req;
    for (int i = 0; i < 8; i++) wr_slot(c[i]);
  endtask

  task automatic rd_slot(input logic want, input string req, output logic got);
    exp_req  = req;
    exp_mode = M_DC;
    m_low = 1'b1;
    wait_us(2);
    m_low = 1'b0;
    exp_mode = want ? M_REL : M_PULL;
    wait_us(13);
    got = line_in;
    chk(got == want, req, 64'(got), 64'(want));
    wait_us(11); exp_mode = M_DC;
    wait_us(8);  exp_mode = M_REL;
    wait_us(36);
  endtask

  task automatic bus_reset(input string req);
    int d, l;
    exp_req  = req;
    exp_mode = M_DC;
    m_low = 1'b1;
    wait_us(40);
    exp_mode = M_REL;
    wait_us(480);
    m_low = 1'b0;
    exp_mode = M_DC;
    d = 0;
    while (pull_n && d < 2000) begin @(negedge clk); d++; end
    chk(d >= 2 * PD_WAIT - 6 && d <= 2 * PD_WAIT + 6, req, 64'(d), 64'(2 * PD_WAIT));
    l = 0;
    while (!pull_n && l < 2000) begin @(negedge clk); l++; end
    chk(l >= 2 * PD_LEN - 6 && l <= 2 * PD_LEN + 6, req, 64'(l), 64'(2 * PD_LEN));
    exp_mode = M_REL;
    wait_us(20);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks + clk_checks,
             errors + clk_errors + wd_err);
    $finish;
  endtask

  initial begin
    repeat (2000000) @(negedge clk);
    wd_err = 1;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    logic g;
    logic [63:0] rd;
    int npull;
    ref_id = {ref_crc({SER, FAM}), SER, FAM};
    // R6: bench CRC against a known identity with CRC A2h
    chk(ref_crc(56'h00_0000_01B8_1C02) == 8'hA2, "R6 crc vector",
        64'(ref_crc(56'h00_0000_01B8_1C02)), 64'hA2);

    repeat (6) @(negedge clk);
    chk(pull_n == 1'b1, "R1 during reset", 64'(pull_n), 64'd1);
    rst = 1'b0;
    exp_mode = M_REL;
    wait_us(5);
    chk(pull_n == 1'b1, "R1 after reset", 64'(pull_n), 64'd1);
    rd_slot(1'b1, "R1 slot before bus reset", g);

    // R3: a 300 us low gives no presence
    exp_req = "R3"; exp_mode = M_DC; m_low = 1'b1;
    wait_us(40); exp_mode = M_REL; wait_us(260); m_low = 1'b0;
    npull = 0;
    for (int i = 0; i < 800; i++) begin @(negedge clk); if (!pull_n) npull++; end
    chk(npull == 0, "R3 no presence", 64'(npull), 64'd0);

    // R2, R4, R5, R6, R7: full read with 33h
    bus_reset("R2 presence");
    send_cmd(8'h33, "R4 command 33h");
    rd = '0;
    for (int i = 0; i < 64; i++) begin
      rd_slot(ref_id[i], "R5 read 33h", g);
      rd[i] = g;
    end
    chk(rd[7:0] == 8'h01, "R6 family byte", 64'(rd[7:0]), 64'h01);
    chk(rd[63:56] == ref_crc(rd[55:0]), "R6 crc byte", 64'(rd[63:56]),
        64'(ref_crc(rd[55:0])));
    chk(rd == ref_id, "R6 identity", rd, ref_id);
    rd_slot(1'b1, "R7 after 64 bits", g);
    rd_slot(1'b1, "R7 after 64 bits", g);

    // R5: second read opcode
    bus_reset("R2 presence");
    send_cmd(8'h0F, "R4 command 0Fh");
    for (int i = 0; i < 16; i++) rd_slot(ref_id[i], "R5 read 0Fh", g);

    // R8: match, skip, unknown
    bus_reset("R2 presence");
    send_cmd(8'h55, "R8 match");
    for (int i = 0; i < 3; i++) rd_slot(1'b1, "R8 silent after 55h", g);
    bus_reset("R2 presence");
    send_cmd(8'hCC, "R8 skip");
    for (int i = 0; i < 3; i++) rd_slot(1'b1, "R8 silent after CCh", g);
    bus_reset("R2 presence");
    send_cmd(8'hA7, "R8 unknown");
    for (int i = 0; i < 3; i++) rd_slot(1'b1, "R8 silent after A7h", g);

    // R9: full search pass
    bus_reset("R2 presence");
    send_cmd(8'hF0, "R4 command F0h");
    for (int i = 0; i < 64; i++) begin
      rd_slot(ref_id[i],  "R9 search bit", g);
      rd_slot(!ref_id[i], "R9 search complement", g);
      exp_req = "R9 search write";
      wr_slot(ref_id[i]);
    end
    rd_slot(1'b1, "R9 silent after pass", g);

    // R10: mismatch at bit 5
    bus_reset("R2 presence");
    send_cmd(8'hF0, "R4 command F0h");
    for (int i = 0; i < 6; i++) begin
      rd_slot(ref_id[i],  "R10 search bit", g);
      rd_slot(!ref_id[i], "R10 search complement", g);
      exp_req = "R10 search write";
      wr_slot(i == 5 ? !ref_id[i] : ref_id[i]);
    end
    rd_slot(1'b1, "R10 dropped out", g);
    rd_slot(1'b1, "R10 dropped out", g);

    // R11: 150 us low mid-read
    bus_reset("R2 presence");
    send_cmd(8'h33, "R4 command 33h");
    for (int i = 0; i < 8; i++) rd_slot(ref_id[i], "R11 read before abort", g);
    exp_req = "R11 abort"; exp_mode = M_DC; m_low = 1'b1;
    wait_us(40); exp_mode = M_REL; wait_us(110); m_low = 1'b0;
    wait_us(20);
    for (int i = 0; i < 4; i++) rd_slot(1'b1, "R11 silent after abort", g);

    // R12: reset in the middle of a read restarts from bit 0
    bus_reset("R2 presence");
    send_cmd(8'h33, "R4 command 33h");
    for (int i = 0; i < 4; i++) rd_slot(ref_id[i], "R12 partial read", g);
    bus_reset("R12 presence mid-read");
    send_cmd(8'h33, "R12 command");
    for (int i = 0; i < 12; i++) rd_slot(ref_id[i], "R12 read restart", g);

    exp_mode = M_DC;
    finish_run();
  end

endmodule